// File: doc/BRIEF.md
# Cooperative Priority Task Arbiter

This block decides which of eight hardware tasks owns a shared microcoded processor. Every device that needs service pulls its own active-low wakeup line and holds it until its microcode has done the work. The running task keeps the processor until it issues a yield function code. The arbiter then takes the highest-numbered task whose wakeup is asserted in that cycle. If no wakeup is asserted, it takes task 0, the background task, which always counts as ready. The outgoing task keeps running for one more cycle. The new task becomes active in the cycle after that, and its device gets a single-cycle active-low acknowledge at that moment.

The arbiter also decodes the two 4-bit function fields of the running microinstruction. Codes 0 to 7 are common to all tasks and produce shared one-hot strobes. Codes 8 to 15 belong to a task: each one produces a strobe only on the lane of the task that was active when the code was issued, so a device never sees strobes meant for another task. All decoded strobes are registered. They are therefore stable for the whole following cycle and can safely gate clocks, even though the raw fields settle only shortly before the edge.

Top module: `taskArbiter`

## Requirements
- R1: While reset is asserted, activeTask is 0, taskActive is 8'b0000_0001, ackN is all ones, and every common and task strobe is 0.
- R2: When fnA equals the yield code 2 in cycle n, and no switch is already under way, the task active in cycle n stays active through cycle n+1. From cycle n+2 the active task is the highest-numbered task t (t from 1 to 7) whose wakeReqN[t] was low in cycle n.
- R3: A yield in a cycle where none of wakeReqN[7:1] is low selects task 0, whatever the value of wakeReqN[0].
- R4: Without a yield, the active task never changes, whatever the wakeup lines do.
- R5: A yield issued in the cycle after an accepted yield (the extra cycle of the outgoing task) is ignored: it neither changes the pending choice nor starts a second switch.
- R6: In the first cycle a newly selected task is active, ackN[task] is low for exactly that one cycle, and no other ackN bit is low. This holds even when the same task is selected again.
- R7: taskActive is one-hot, with bit activeTask set.
- R8: A field value v from 0 to 7 on fnA (or fnB) in cycle n sets bit v of commonStrA (or commonStrB), and only that bit, during cycle n+1, for any active task. An upper value leaves that common strobe at 0.
- R9: A field value 8+k on fnA (or fnB) in cycle n sets bit t*8+k of taskStrA (or taskStrB), and only that bit, during cycle n+1, where t is the task active in cycle n. A lower value leaves those strobes at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wakeReqN | input | 8 | Active-low wakeup request, one per task; bit 0 has no effect |
| fnA | input | 4 | First function field of the running microinstruction |
| fnB | input | 4 | Second function field of the running microinstruction |
| activeTask | output | 3 | Number of the task that owns the processor |
| taskActive | output | 8 | One-hot active-task indication |
| ackN | output | 8 | Active-low single-cycle acknowledge to the newly activated task |
| commonStrA | output | 8 | Registered one-hot decode of fnA codes 0 to 7 |
| commonStrB | output | 8 | Registered one-hot decode of fnB codes 0 to 7 |
| taskStrA | output | 64 | Registered decode of fnA codes 8 to 15, eight lanes per task |
| taskStrB | output | 64 | Registered decode of fnB codes 8 to 15, eight lanes per task |

## Verification
The assertions check four properties on every cycle:
- every change of the active task carries exactly one acknowledge, on the new task, for exactly one cycle;
- the active task only changes two cycles after a yield code;
- task strobes appear only on the lane of the task that was active in the previous cycle;
- a field never produces a common strobe and a task strobe together.

Which task wins a given request pattern can only be shown by the bench's scenarios. The same holds for falling back to task 0 with bit 0 ignored, dropping a yield in the extra cycle, and the exact bit position of each decoded code. For these the bench compares every cycle against a model built from the requirements.

// File: rtl/taskArbPkg.sv
package taskArbPkg;
  localparam int NUM_TASKS = 8;
  localparam int TASK_W = $clog2(NUM_TASKS);

  // strobes from the switch control to the datapath
  typedef struct packed {
    logic load;
    logic [TASK_W-1:0] nextTask;
  } swStrobe_t;
endpackage

// File: rtl/prioPick.sv
module prioPick #(
  parameter int N = 8,
  parameter int TW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic [TW-1:0] idx
);
  // later (higher) indices overwrite earlier ones: highest number wins
  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i]) idx = TW'(i);
    end
  end
endmodule

// File: rtl/taskSwitchCtl.sv
module taskSwitchCtl
  import taskArbPkg::*;
#(
  parameter int FN_W = 4,
  parameter int YIELD_CODE = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [NUM_TASKS-1:0] wakeReqN,
  input  logic [FN_W-1:0]  fnA,
  output swStrobe_t        sw
);
  logic [NUM_TASKS-1:0] reqHot;
  logic [TASK_W-1:0]    winner;
  logic                 pend;
  logic [TASK_W-1:0]    pendTask;
  logic                 yieldNow;

  // background task always counts as requesting
  assign reqHot = ~wakeReqN | NUM_TASKS'(1);

  prioPick #(.N(NUM_TASKS), .TW(TASK_W)) u_pick (
    .req(reqHot),
    .idx(winner)
  );

  // a yield during the outgoing task's extra cycle is dropped
  assign yieldNow = (fnA == FN_W'(YIELD_CODE)) && !pend;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pend     <= 1'b0;
      pendTask <= '0;
    end else begin
      pend <= yieldNow;
      if (yieldNow) pendTask <= winner;
    end
  end

  assign sw.load     = pend;
  assign sw.nextTask = pendTask;
endmodule

// File: rtl/fnFieldDecode.sv
module fnFieldDecode #(
  parameter int FN_W = 4,
  parameter int NUM = 8,
  parameter int TW = 3,
  localparam int HALF = 1 << (FN_W - 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [FN_W-1:0]     fn,
  input  logic [TW-1:0]       owner,
  output logic [HALF-1:0]     commonStr,
  output logic [NUM*HALF-1:0] taskStr
);
  logic              upper;
  logic [FN_W-2:0]   code;
  logic [HALF-1:0]   codeHot;
  logic [HALF-1:0]   commonNext;
  logic [NUM*HALF-1:0] taskNext;

  assign upper = fn[FN_W-1];
  assign code  = fn[FN_W-2:0];

  always_comb begin
    codeHot = '0;
    codeHot[code] = 1'b1;
  end

  assign commonNext = upper ? '0 : codeHot;

  // one lane group per task, enabled only for the owner
  for (genvar t = 0; t < NUM; t++) begin : g_lane
    assign taskNext[t*HALF +: HALF] =
      (upper && (owner == TW'(t))) ? codeHot : '0;
  end

  // registered so strobes are stable for a full cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      commonStr <= '0;
      taskStr   <= '0;
    end else begin
      commonStr <= commonNext;
      taskStr   <= taskNext;
    end
  end
endmodule

// File: rtl/taskFnDatapath.sv
module taskFnDatapath
  import taskArbPkg::*;
#(
  parameter int FN_W = 4,
  localparam int HALF = 1 << (FN_W - 1)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  swStrobe_t                 sw,
  input  logic [FN_W-1:0]           fnA,
  input  logic [FN_W-1:0]           fnB,
  output logic [TASK_W-1:0]         activeTask,
  output logic [NUM_TASKS-1:0]      taskActive,
  output logic [NUM_TASKS-1:0]      ackN,
  output logic [HALF-1:0]           commonStrA,
  output logic [HALF-1:0]           commonStrB,
  output logic [NUM_TASKS*HALF-1:0] taskStrA,
  output logic [NUM_TASKS*HALF-1:0] taskStrB
);
  logic [FN_W-1:0]           fnArr  [2];
  logic [HALF-1:0]           comArr [2];
  logic [NUM_TASKS*HALF-1:0] tskArr [2];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeTask <= '0;
      ackN       <= '1;
    end else begin
      ackN <= '1;
      if (sw.load) begin
        activeTask        <= sw.nextTask;
        ackN[sw.nextTask] <= 1'b0;
      end
    end
  end

  for (genvar t = 0; t < NUM_TASKS; t++) begin : g_act
    assign taskActive[t] = (activeTask == TASK_W'(t));
  end

  assign fnArr[0] = fnA;
  assign fnArr[1] = fnB;

  for (genvar f = 0; f < 2; f++) begin : g_field
    fnFieldDecode #(.FN_W(FN_W), .NUM(NUM_TASKS), .TW(TASK_W)) u_dec (
      .clk      (clk),
      .rstN     (rstN),
      .fn       (fnArr[f]),
      .owner    (activeTask),
      .commonStr(comArr[f]),
      .taskStr  (tskArr[f])
    );
  end

  assign commonStrA = comArr[0];
  assign commonStrB = comArr[1];
  assign taskStrA   = tskArr[0];
  assign taskStrB   = tskArr[1];
endmodule

// File: rtl/taskArbiter.sv
module taskArbiter
  import taskArbPkg::*;
#(
  parameter int FN_W = 4,
  parameter int YIELD_CODE = 2,
  localparam int HALF = 1 << (FN_W - 1)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_TASKS-1:0]      wakeReqN,
  input  logic [FN_W-1:0]           fnA,
  input  logic [FN_W-1:0]           fnB,
  output logic [TASK_W-1:0]         activeTask,
  output logic [NUM_TASKS-1:0]      taskActive,
  output logic [NUM_TASKS-1:0]      ackN,
  output logic [HALF-1:0]           commonStrA,
  output logic [HALF-1:0]           commonStrB,
  output logic [NUM_TASKS*HALF-1:0] taskStrA,
  output logic [NUM_TASKS*HALF-1:0] taskStrB
);
  swStrobe_t ctlBus;

  taskSwitchCtl #(.FN_W(FN_W), .YIELD_CODE(YIELD_CODE)) u_ctl (
    .clk     (clk),
    .rstN    (rstN),
    .wakeReqN(wakeReqN),
    .fnA     (fnA),
    .sw      (ctlBus)
  );

  taskFnDatapath #(.FN_W(FN_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .sw        (ctlBus),
    .fnA       (fnA),
    .fnB       (fnB),
    .activeTask(activeTask),
    .taskActive(taskActive),
    .ackN      (ackN),
    .commonStrA(commonStrA),
    .commonStrB(commonStrB),
    .taskStrA  (taskStrA),
    .taskStrB  (taskStrB)
  );
endmodule

// File: rtl/taskArbChecker.sv
module taskArbChecker
  import taskArbPkg::*;
#(
  parameter int FN_W = 4,
  parameter int YIELD_CODE = 2,
  localparam int HALF = 1 << (FN_W - 1)
) (
  input logic                      clk,
  input logic                      rstN,
  input logic [FN_W-1:0]           fnA,
  input logic [TASK_W-1:0]         activeTask,
  input logic [NUM_TASKS-1:0]      ackN,
  input logic [HALF-1:0]           commonStrA,
  input logic [HALF-1:0]           commonStrB,
  input logic [NUM_TASKS*HALF-1:0] taskStrA,
  input logic [NUM_TASKS*HALF-1:0] taskStrB
);
  logic [TASK_W-1:0]         prevTask;
  logic [NUM_TASKS*HALF-1:0] ownMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevTask <= '0;
    else       prevTask <= activeTask;
  end

  assign ownMask = {{(NUM_TASKS*HALF-HALF){1'b0}}, {HALF{1'b1}}} << (HALF * int'(prevTask));

  // R6: a change of owner always comes with an acknowledge
  p_switch_acked_r6: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(activeTask) |-> (ackN != '1));

  // R6: the acknowledge is single and goes to the active task
  p_ack_target_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ackN != '1) |-> ($countones(~ackN) == 1 && !ackN[activeTask]));

  // R6: the acknowledge lasts one cycle
  p_ack_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ackN != '1) |=> (ackN == '1));

  // R4: owner changes only two cycles after a yield code
  p_switch_needs_yield_r4: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(activeTask) |-> ($past(fnA, 2) == FN_W'(YIELD_CODE)));

  // R9: task strobes only on the lane of the previous owner
  p_lane_owner_a_r9: assert property (@(posedge clk) disable iff (!rstN)
    (taskStrA & ~ownMask) == '0);
  p_lane_owner_b_r9: assert property (@(posedge clk) disable iff (!rstN)
    (taskStrB & ~ownMask) == '0);

  // R8: a field yields either a common or a task strobe, never both
  p_half_excl_a_r8: assert property (@(posedge clk) disable iff (!rstN)
    (|commonStrA) |-> !(|taskStrA));
  p_half_excl_b_r8: assert property (@(posedge clk) disable iff (!rstN)
    (|commonStrB) |-> !(|taskStrB));
endmodule

bind taskArbiter taskArbChecker #(.FN_W(FN_W), .YIELD_CODE(YIELD_CODE)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .fnA       (fnA),
  .activeTask(activeTask),
  .ackN      (ackN),
  .commonStrA(commonStrA),
  .commonStrB(commonStrB),
  .taskStrA  (taskStrA),
  .taskStrB  (taskStrB)
);

// File: tb/tb_taskArbiter.sv
`timescale 1ns/1ps
module tb_taskArbiter;
  localparam int YIELD = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  wakeReqN = 8'hFF;
  logic [3:0]  fnA = 4'd0;
  logic [3:0]  fnB = 4'd0;
  logic [2:0]  activeTask;
  logic [7:0]  taskActive;
  logic [7:0]  ackN;
  logic [7:0]  commonStrA, commonStrB;
  logic [63:0] taskStrA, taskStrB;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  taskArbiter dut (
    .clk(clk), .rstN(rstN), .wakeReqN(wakeReqN), .fnA(fnA), .fnB(fnB),
    .activeTask(activeTask), .taskActive(taskActive), .ackN(ackN),
    .commonStrA(commonStrA), .commonStrB(commonStrB),
    .taskStrA(taskStrA), .taskStrB(taskStrB)
  );

  typedef struct {
    logic [2:0]  act;
    logic [7:0]  ack;
    logic [7:0]  comA, comB;
    logic [63:0] tskA, tskB;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];

  // reference state built from the requirements
  logic [2:0] mAct = 3'd0;
  bit         mPend = 1'b0;
  logic [2:0] mPendTask = 3'd0;

  function automatic logic [2:0] pickWinner(input logic [7:0] req);
    logic [2:0] w = 3'd0;
    for (int t = 1; t < 8; t++) if (!req[t]) w = 3'(t);
    return w;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic [3:0] a, input logic [3:0] b, input logic [7:0] req, input string tag);
    expItem_t it;
    @(negedge clk);
    fnA = a; fnB = b; wakeReqN = req;
    it.act  = mPend ? mPendTask : mAct;
    it.ack  = mPend ? ~(8'b1 << mPendTask) : 8'hFF;
    it.comA = a[3] ? 8'h0 : (8'b1 << a[2:0]);
    it.comB = b[3] ? 8'h0 : (8'b1 << b[2:0]);
    it.tskA = a[3] ? (64'b1 << (int'(mAct) * 8 + int'(a[2:0]))) : 64'h0;
    it.tskB = b[3] ? (64'b1 << (int'(mAct) * 8 + int'(b[2:0]))) : 64'h0;
    it.tag  = tag;
    expQ.push_back(it);
    if (!mPend && a == 4'(YIELD)) begin
      mPendTask = pickWinner(req);
      mPend = 1'b1;
    end else begin
      mPend = 1'b0;
    end
    mAct = it.act;
  endtask

  // monitor: samples 5 ns after each rising edge
  always @(posedge clk) begin
    #5;
    if (expQ.size() > 0) begin
      expItem_t e;
      e = expQ.pop_front();
      check(activeTask == e.act, e.tag, 64'(activeTask), 64'(e.act));
      check(taskActive == (8'b1 << e.act), "R7", 64'(taskActive), 64'(8'b1 << e.act));
      check(ackN == e.ack, "R6", 64'(ackN), 64'(e.ack));
      check(commonStrA == e.comA && commonStrB == e.comB, "R8",
            {48'h0, commonStrA, commonStrB}, {48'h0, e.comA, e.comB});
      check(taskStrA == e.tskA, "R9", taskStrA, e.tskA);
      check(taskStrB == e.tskB, "R9", taskStrB, e.tskB);
    end
  end

  initial begin
    int cyc = 0;
    while (!finished && cyc < 200000) begin
      @(posedge clk);
      cyc++;
    end
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=<200000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    check(activeTask == 3'd0 && taskActive == 8'h01 && ackN == 8'hFF, "R1",
          {40'h0, activeTask, taskActive, ackN}, {40'h0, 3'd0, 8'h01, 8'hFF});
    check(commonStrA == 0 && commonStrB == 0 && taskStrA == 0 && taskStrB == 0, "R1",
          taskStrA | taskStrB | 64'(commonStrA) | 64'(commonStrB), 64'h0);
    rstN = 1'b1;

    // R4: requests without a yield leave task 0 running
    for (int i = 0; i < 4; i++) step(4'd0, 4'd1, 8'b1101_1111, "R4");
    // R2: yield with tasks 5 and 3 pending picks 5
    step(4'(YIELD), 4'd9, 8'b1101_0111, "R2");
    // R5: yield in the extra cycle with task 7 pending is dropped
    step(4'(YIELD), 4'hC, 8'b0111_1111, "R5");
    step(4'd0, 4'hB, 8'b0111_1111, "R2");
    step(4'hA, 4'd3, 8'b0111_1111, "R5");
    step(4'hF, 4'd7, 8'b0111_1111, "R5");
    // R9: upper codes now land on task 5 lanes; then yield to 7
    step(4'(YIELD), 4'h8, 8'b0111_1111, "R2");
    step(4'd0, 4'd0, 8'b1111_1111, "R2");
    step(4'hD, 4'hE, 8'b1111_1111, "R2");
    // R4: requests withdrawn, no yield, task 7 holds
    step(4'd0, 4'd0, 8'b1111_1111, "R4");
    // R3: nothing pending, bit 0 low is ignored -> task 0
    step(4'(YIELD), 4'd0, 8'b1111_1110, "R3");
    step(4'd0, 4'd0, 8'b1111_1110, "R3");
    step(4'd0, 4'd0, 8'b1111_1111, "R3");
    step(4'd0, 4'd0, 8'b1111_1111, "R3");
    // R6: re-selecting the same task still acknowledges it
    step(4'(YIELD), 4'd0, 8'b1111_1111, "R6");
    step(4'd0, 4'd0, 8'b1111_1111, "R6");
    step(4'd0, 4'd0, 8'b1111_1111, "R6");
    // mixed patterns
    for (int i = 0; i < 60; i++)
      step(4'((i * 5) % 16), 4'((i * 7 + 3) % 16), ~8'(i * 37 + 11), "R2");
    step(4'd0, 4'd0, 8'hFF, "R2");
    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule